// File: doc/BRIEF.md
# Read-Data Parity Checker with Error Latch

This block sits beside a 64-bit read data path and checks byte parity on every beat that the bus marks ready. Each byte has its own even-parity bit and its own valid enable. Only bytes flagged valid are judged. The combined result appears on an active-low check output exactly two clocks after the ready strobe, as a one-clock low pulse for each beat that carried a bad valid byte.

The address and control of each beat travel through the same two-stage pipeline as the error result. A parity-enable input is sampled in the clock in which the check output is low. If it is active, the failing beat's address, control and byte-error mask are latched into a set of machine-check registers. If a machine-check enable bit is also set in that clock, an exception request is raised and held. The registers keep the first capture until a clear pulse empties them.

Top module: `rd_parity_chk`

## Requirements
- R1: Byte i is in error when the XOR of `rd_data[8*i+7:8*i]` and `rd_par[i]` is 1, which is even parity across nine bits.
- R2: A byte whose `rd_be[i]` is 0 never causes an error, whatever its data and parity.
- R3: When `rd_rdy` is 1 in clock c and at least one valid byte is in error, `chk_n` is 0 in clock c+2. When no valid byte is in error, `chk_n` is 1 in clock c+2.
- R4: Each erroneous ready clock gives exactly one low clock on `chk_n`. Erroneous beats in consecutive clocks give consecutive low clocks, and a clean beat between them gives a high clock.
- R5: Data, parity and enables are ignored in clocks where `rd_rdy` is 0, and `chk_n` stays 1 two clocks later.
- R6: If `par_en` is 1 in a clock where `chk_n` is 0 and nothing is held, the next clock shows `cap_valid`=1 and the following captured values: `cap_addr` and `cap_ctrl` equal `rd_addr` and `rd_ctrl` of the failing beat, and `cap_mask` has bit i set for each valid byte that was in error.
- R7: `mc_req` becomes 1 together with a capture only if `mce` is 1 in the capturing clock. Once set, it stays 1 until cleared.
- R8: If `par_en` is 0 while `chk_n` is 0, the low pulse still appears, but nothing is captured and `mc_req` stays 0.
- R9: While `cap_valid` is 1, later errors do not change `cap_addr`, `cap_ctrl` or `cap_mask`.
- R10: A `clr` pulse in clock c makes `cap_valid` and `mc_req` 0 in clock c+1. This clear wins over a capture requested in the same clock, and that capture is dropped.
- R11: Synchronous active-high `rst` sets `chk_n` to 1 and clears `cap_valid`, `mc_req` and the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_rdy | input | 1 | Ready strobe: a data beat is present |
| rd_data | input | DATA_W | Read data |
| rd_par | input | DATA_W/8 | Even parity bit per byte |
| rd_be | input | DATA_W/8 | Per-byte valid enable |
| rd_addr | input | ADDR_W | Address of the beat |
| rd_ctrl | input | CTRL_W | Control attributes of the beat |
| par_en | input | 1 | Allows capture of a failing beat |
| mce | input | 1 | Machine-check enable bit |
| clr | input | 1 | Clears the capture registers and the request |
| chk_n | output | 1 | Active-low parity error, two clocks after ready |
| cap_valid | output | 1 | Capture registers hold an error |
| cap_addr | output | ADDR_W | Captured address |
| cap_ctrl | output | CTRL_W | Captured control |
| cap_mask | output | DATA_W/8 | Captured per-byte error mask |
| mc_req | output | 1 | Machine-check exception request |

## Verification
The properties assume that every input is known at each rising edge, and that `clr` is a pulse and not a level held across a capture. They also assume that reset lasts at least one edge, so that the two-clock delay checks start from an empty pipeline. The stimulus changes inputs only on falling edges, drives every bus field to a defined value even when `rd_rdy` is 0, and keeps `clr` high for a single clock at a time.

// File: rtl/rd_parity_chk.sv
`timescale 1ns/1ps
module rd_parity_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32,
  parameter int CTRL_W = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_rdy,
  input  logic [DATA_W-1:0]      rd_data,
  input  logic [DATA_W/8-1:0]    rd_par,
  input  logic [DATA_W/8-1:0]    rd_be,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [CTRL_W-1:0]      rd_ctrl,
  input  logic                   par_en,
  input  logic                   mce,
  input  logic                   clr,
  output logic                   chk_n,
  output logic                   cap_valid,
  output logic [ADDR_W-1:0]      cap_addr,
  output logic [CTRL_W-1:0]      cap_ctrl,
  output logic [DATA_W/8-1:0]    cap_mask,
  output logic                   mc_req
);
  localparam int NB = DATA_W / 8;

  logic [NB-1:0]     bad, hit;
  logic [NB-1:0]     a_mask, b_mask;
  logic [ADDR_W-1:0] a_addr, b_addr;
  logic [CTRL_W-1:0] a_ctrl, b_ctrl;
  logic              take;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    assign bad[i] = ^{rd_data[8*i +: 8], rd_par[i]};
  end

  assign hit   = bad & rd_be & {NB{rd_rdy}};
  assign chk_n = ~|b_mask;
  assign take  = ~chk_n & par_en & ~cap_valid & ~clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_mask <= '0;
      b_mask <= '0;
      a_addr <= '0;
      b_addr <= '0;
      a_ctrl <= '0;
      b_ctrl <= '0;
    end else begin
      a_mask <= hit;
      a_addr <= rd_addr;
      a_ctrl <= rd_ctrl;
      b_mask <= a_mask;
      b_addr <= a_addr;
      b_ctrl <= a_ctrl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_valid <= 1'b0;
      cap_addr  <= '0;
      cap_ctrl  <= '0;
      cap_mask  <= '0;
      mc_req    <= 1'b0;
    end else if (clr) begin
      cap_valid <= 1'b0;
      mc_req    <= 1'b0;
    end else if (take) begin
      cap_valid <= 1'b1;
      cap_addr  <= b_addr;
      cap_ctrl  <= b_ctrl;
      cap_mask  <= b_mask;
      mc_req    <= mce;
    end
  end
endmodule

// File: rtl/rd_parity_chk_sva.sv
`timescale 1ns/1ps
module rd_parity_chk_sva #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                rd_rdy,
  input logic [DATA_W-1:0]   rd_data,
  input logic [DATA_W/8-1:0] rd_par,
  input logic [DATA_W/8-1:0] rd_be,
  input logic                par_en,
  input logic                clr,
  input logic                chk_n,
  input logic                cap_valid,
  input logic [ADDR_W-1:0]   cap_addr,
  input logic                mc_req
);
  localparam int NB = DATA_W / 8;
  logic [NB-1:0] odd;
  for (genvar i = 0; i < NB; i++) begin : g_odd
    assign odd[i] = ^{rd_data[8*i +: 8], rd_par[i]};
  end

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (chk_n && !cap_valid && !mc_req)); // R11
  AST_CLEAN_BEAT: assert property (@(posedge clk) disable iff (rst) (rd_rdy && ((odd & rd_be) == '0)) |-> ##2 chk_n); // R2
  AST_BAD_BEAT: assert property (@(posedge clk) disable iff (rst) (rd_rdy && ((odd & rd_be) != '0)) |-> ##2 !chk_n); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !rd_rdy |-> ##2 chk_n); // R5
  AST_NO_PEN_NO_CAP: assert property (@(posedge clk) disable iff (rst) (!par_en && !cap_valid) |=> !cap_valid); // R8
  AST_REQ_NEEDS_CAP: assert property (@(posedge clk) disable iff (rst) mc_req |-> cap_valid); // R7
  AST_CAP_HELD: assert property (@(posedge clk) disable iff (rst) (cap_valid && !clr) |=> (cap_valid && $stable(cap_addr))); // R9
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst) clr |=> (!cap_valid && !mc_req)); // R10
endmodule

bind rd_parity_chk rd_parity_chk_sva #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst(rst), .rd_rdy(rd_rdy), .rd_data(rd_data), .rd_par(rd_par),
  .rd_be(rd_be), .par_en(par_en), .clr(clr), .chk_n(chk_n),
  .cap_valid(cap_valid), .cap_addr(cap_addr), .mc_req(mc_req)
);

// File: tb/rd_parity_chk_test.sv
`timescale 1ns/1ps
module rd_parity_chk_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        rd_rdy;
  logic [63:0] rd_data;
  logic [7:0]  rd_par, rd_be;
  logic [31:0] rd_addr;
  logic [4:0]  rd_ctrl;
  logic        par_en, mce, clr;
  logic        chk_n, cap_valid, mc_req;
  logic [31:0] cap_addr;
  logic [4:0]  cap_ctrl;
  logic [7:0]  cap_mask;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rd_parity_chk uut (
    .clk(clk), .rst(rst), .rd_rdy(rd_rdy), .rd_data(rd_data), .rd_par(rd_par),
    .rd_be(rd_be), .rd_addr(rd_addr), .rd_ctrl(rd_ctrl), .par_en(par_en),
    .mce(mce), .clr(clr), .chk_n(chk_n), .cap_valid(cap_valid),
    .cap_addr(cap_addr), .cap_ctrl(cap_ctrl), .cap_mask(cap_mask), .mc_req(mc_req)
  );

  typedef struct packed {
    logic [63:0] d;
    logic [7:0]  flip;
    logic [7:0]  be;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{64'h0123_4567_89AB_CDEF, 8'h00, 8'hFF},
    '{64'hFFFF_FFFF_FFFF_FFFF, 8'h01, 8'hFF},
    '{64'h8000_0000_0000_0001, 8'h80, 8'hFF},
    '{64'h55AA_55AA_0F0F_F0F0, 8'h10, 8'h0F},
    '{64'h55AA_55AA_0F0F_F0F0, 8'h10, 8'h1F},
    '{64'hDEAD_BEEF_CAFE_F00D, 8'hFF, 8'h00},
    '{64'h1357_9BDF_2468_ACE0, 8'h24, 8'h20},
    '{64'h0000_0000_0000_0000, 8'h00, 8'h00}
  };

  function automatic logic [7:0] mkpar(input logic [63:0] d);
    for (int i = 0; i < 8; i++) mkpar[i] = ^d[8*i +: 8];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [63:0] d, input logic [7:0] flip,
                       input logic [7:0] be, input logic [31:0] a, input logic [4:0] c);
    rd_rdy  = v;
    rd_data = d;
    rd_par  = mkpar(d) ^ flip;
    rd_be   = be;
    rd_addr = a;
    rd_ctrl = c;
  endtask

  // drive at a falling edge, return at the falling edge where chk_n shows the result
  task automatic send(input logic [63:0] d, input logic [7:0] flip, input logic [7:0] be,
                      input logic [31:0] a, input logic [4:0] c);
    drive(1'b1, d, flip, be, a, c);
    @(negedge clk);
    drive(1'b0, 64'h0, 8'hFF, 8'hFF, 32'h0, 5'h0);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] bpat;
    rst = 1'b1; par_en = 1'b0; mce = 1'b0; clr = 1'b0;
    drive(1'b0, 64'h0, 8'h0, 8'h0, 32'h0, 5'h0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R11 chk_n", chk_n, 1);
    check("R11 cap_valid", cap_valid, 0);
    check("R11 mc_req", mc_req, 0);

    // R1 R2 R3: table walk, parity enable off
    foreach (VECS[k]) begin
      send(VECS[k].d, VECS[k].flip, VECS[k].be, 32'h100 + k, 5'(k));
      check("R1/R2/R3 table", chk_n, !(|(VECS[k].flip & VECS[k].be)));
      @(negedge clk);
      check("R3 single pulse", chk_n, 1);
    end
    check("R8 no capture", cap_valid, 0);
    check("R8 no request", mc_req, 0);

    // R5: bad data without ready
    drive(1'b0, 64'hFFFF_0000_FFFF_0000, 8'hFF, 8'hFF, 32'h5, 5'h1);
    @(negedge clk); @(negedge clk);
    check("R5 ignored", chk_n, 1);
    @(negedge clk);
    check("R5 ignored", chk_n, 1);

    // R4: burst of four beats, error pattern 1,1,0,1
    bpat = 4'b1011;
    for (int j = 0; j < 6; j++) begin
      if (j < 4) drive(1'b1, 64'hA5A5_0000_1111_2222 + 64'(j), {7'h0, bpat[j]}, 8'hFF, 32'h200 + j, 5'h2);
      else       drive(1'b0, 64'h0, 8'h0, 8'h0, 32'h0, 5'h0);
      if (j >= 2) check("R4 burst", chk_n, !bpat[j-2]);
      @(negedge clk);
    end

    // R6: capture with parity enable, mce low
    par_en = 1'b1;
    send(64'h0011_2233_4455_6677, 8'h42, 8'h4F, 32'hCAFE_0001, 5'h13);
    check("R6 pulse", chk_n, 0);
    @(negedge clk);
    check("R6 cap_valid", cap_valid, 1);
    check("R6 cap_addr", cap_addr, 32'hCAFE_0001);
    check("R6 cap_ctrl", cap_ctrl, 5'h13);
    check("R6 cap_mask", cap_mask, 8'h42);
    check("R7 no req without mce", mc_req, 0);

    // R9: second error does not overwrite
    mce = 1'b1;
    send(64'h0, 8'h01, 8'hFF, 32'hBEEF_0002, 5'h04);
    check("R9 pulse", chk_n, 0);
    @(negedge clk);
    check("R9 addr held", cap_addr, 32'hCAFE_0001);
    check("R9 ctrl held", cap_ctrl, 5'h13);
    check("R9 mask held", cap_mask, 8'h42);
    check("R9 no late req", mc_req, 0);

    // R10: clear
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    check("R10 cleared", cap_valid, 0);

    // R7: capture with mce set
    send(64'h7, 8'h80, 8'h80, 32'h0000_0333, 5'h1F);
    @(negedge clk);
    check("R7 req", mc_req, 1);
    check("R7 cap_addr", cap_addr, 32'h0000_0333);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    check("R10 req cleared", mc_req, 0);

    // R10: clear in the same clock as a capture
    send(64'h9, 8'h02, 8'h02, 32'h444, 5'h3);
    check("R10 pulse", chk_n, 0);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    check("R10 clear wins", cap_valid, 0);
    check("R10 clear wins req", mc_req, 0);
    @(negedge clk);
    check("R10 capture dropped", cap_valid, 0);

    // R8: parity enable low with mce high
    par_en = 1'b0;
    send(64'h5, 8'h04, 8'h04, 32'h555, 5'h5);
    check("R8 pulse still", chk_n, 0);
    @(negedge clk);
    check("R8 no capture", cap_valid, 0);
    check("R8 no req", mc_req, 0);

    // R11: reset in flight
    par_en = 1'b1;
    send(64'h6, 8'h08, 8'h08, 32'h666, 5'h6);
    @(negedge clk);
    check("R11 pre-reset capture", cap_valid, 1);
    drive(1'b1, 64'h0, 8'hFF, 8'hFF, 32'h0, 5'h0);
    rst = 1'b1; @(negedge clk);
    drive(1'b0, 64'h0, 8'h0, 8'h0, 32'h0, 5'h0);
    rst = 1'b0;
    check("R11 cap cleared", cap_valid, 0);
    check("R11 req cleared", mc_req, 0);
    @(negedge clk);
    check("R11 pipeline flushed", chk_n, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule